// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Error Status

This block receives asynchronous serial characters. A sampling tick at sixteen times the bit rate comes either from an internal baud tick or from the rising edges of an external clock pin. The tick drives a deframer that confirms each start bit, samples every data bit at its centre, and optionally checks a parity bit. Characters of 7, 8 or 9 data bits go into a one-entry receive buffer that the host reads. A loopback setting takes the input from the local transmitter's output and uses nine-bit framing.

The host sees a buffer-full flag, the received ninth bit, and four sticky error flags (overrun, framing, parity, break). A status read clears the error flags. The host also sees their OR, a receive-active indicator that stays high after a bad stop bit until the line returns high, and an attention mode for address-wake reception. One interrupt request, gated by an enable bit, is raised while the buffer holds a character or any error flag is set.

Top module: `serial_rx_top`

## Requirements
- R1: After reset the buffer reads 0, and full, all four error flags, err, attention, the interrupt enable, irq and rx_active are all 0.
- R2: frame_mode_i picks the character length: 00 is 8 bits, 01 is 7 bits, 10 is 9 bits, and 11 is 9 bits taken from tx_loop_i instead of rx_i. Bits arrive LSB first and sit right-aligned in rx_data_o, with zeros above the character. In nine-bit modes bit 8 of rx_data_o and bit9_o both carry the ninth bit.
- R3: full_o sets when a character is loaded. A one-cycle rd_data_i pulse clears it. irq_o equals the enable bit AND (full_o OR err_o).
- R4: A character that completes while full_o is high sets overrun_o, and the buffer keeps the earlier character.
- R5: With parity_en_i high in 7- or 8-bit mode, one parity bit follows the data. A mismatch sets parity_o, where parity_odd_i=0 asks for even parity and 1 asks for odd parity. In nine-bit modes no parity bit is expected.
- R6: A stop bit that samples low sets framing_o, unless the frame is a break.
- R7: A frame whose start, data, parity and stop samples are all low sets break_o and not framing_o. After any low stop bit, rx_active_o stays high until the line is seen high again.
- R8: The error flags are sticky until a one-cycle rd_status_i pulse, which clears all four. err_o is their OR.
- R9: attn_we_i writes attn_d_i into the attention bit. While it is set, characters whose ninth bit is 0 (every 7- or 8-bit character) are dropped without touching the buffer or the flags. A character with its ninth bit set is accepted and clears attention.
- R10: A low pulse on the line that is no longer than a quarter bit is not taken as a start bit.
- R11: With clk_sel_i=1 the sampling tick comes from the rising edges of ext_clk_i.
- R12: ie_we_i writes ie_d_i into the interrupt enable. While the enable is 0, irq_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick_i | input | 1 | Internal 16x sampling tick, one cycle wide |
| ext_clk_i | input | 1 | External 16x sampling clock pin |
| clk_sel_i | input | 1 | 1 selects ext_clk_i as the tick source |
| rx_i | input | 1 | Serial receive line |
| tx_loop_i | input | 1 | Local transmitter output, used in loopback |
| frame_mode_i | input | 2 | Character length and loopback select |
| parity_en_i | input | 1 | Parity bit present (7/8-bit modes) |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| attn_we_i | input | 1 | Write strobe for the attention bit |
| attn_d_i | input | 1 | Value written into the attention bit |
| ie_we_i | input | 1 | Write strobe for the interrupt enable |
| ie_d_i | input | 1 | Value written into the interrupt enable |
| rd_data_i | input | 1 | Host read of the receive buffer |
| rd_status_i | input | 1 | Host read of the status flags |
| rx_data_o | output | 9 | Receive buffer |
| bit9_o | output | 1 | Ninth bit of the buffered character |
| full_o | output | 1 | Buffer holds an unread character |
| overrun_o | output | 1 | Sticky overrun flag |
| framing_o | output | 1 | Sticky framing flag |
| parity_o | output | 1 | Sticky parity flag |
| break_o | output | 1 | Sticky break flag |
| err_o | output | 1 | OR of the four error flags |
| rx_active_o | output | 1 | High from a low stop bit until the line is high |
| attn_o | output | 1 | Attention mode bit |
| irq_o | output | 1 | Gated receive interrupt request |

## Verification
The bench sends a second character into a full buffer. A design that overwrote the buffer would show the newer value, and one that dropped the flag would leave overrun_o low. It sends an all-zero frame with a low stop bit, which a careless design would report as a framing error or would decode as a stream of further characters while the line stays low. A quarter-bit low glitch would be caught as a spurious character by a design that does not confirm the start bit at mid-bit. In attention mode a non-address character is sent first: a design that did not discard it would set full_o, and one that failed to leave attention would reject the following address character.

// File: rtl/srx_pkg.sv
package srx_pkg;
   localparam int unsigned SRX_MAXB = 9;

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
   } srx_state_e;

   typedef struct packed {
      logic [SRX_MAXB-1:0] data;
      logic                stop_ok;
      logic                par_bad;
      logic                all_low;
   } srx_frame_t;
endpackage

// File: rtl/srx_insel.sv
module srx_insel #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_CLK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   input  logic loop_i,
   input  logic loop_sel,
   input  logic ext_clk_i,
   input  logic clk_sel,
   input  logic baud_tick_i,
   output logic rx_s,
   output logic tick
);
   logic                   line_mux;
   logic [SYNC_STAGES-1:0] rx_q;
   logic                   ext_rise;

   assign line_mux = loop_sel ? loop_i : rx_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= '1;
      else        rx_q <= {rx_q[SYNC_STAGES-2:0], line_mux};
   end
   assign rx_s = rx_q[SYNC_STAGES-1];

   generate
      if (EXT_CLK_EN) begin : g_ext
         logic [SYNC_STAGES:0] ck_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ck_q <= '0;
            else        ck_q <= {ck_q[SYNC_STAGES-1:0], ext_clk_i};
         end
         assign ext_rise = ck_q[SYNC_STAGES-1] & ~ck_q[SYNC_STAGES];
      end else begin : g_noext
         assign ext_rise = 1'b0;
      end
   endgenerate

   assign tick = clk_sel ? ext_rise : baud_tick_i;
endmodule

// File: rtl/srx_deframe.sv
module srx_deframe
   import srx_pkg::*;
#(
   parameter int unsigned OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx,
   input  logic [3:0] nbits,
   input  logic       par_en,
   input  logic       par_odd,
   output logic       done,
   output srx_frame_t frame,
   output logic       active
);
   localparam int unsigned CNT_W = $clog2(OSR);
   localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   srx_state_e          st;
   logic [CNT_W-1:0]    cnt;
   logic [3:0]          idx;
   logic [SRX_MAXB-1:0] sh;
   logic                allz, par_acc, par_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; cnt <= '0; idx <= '0; sh <= '0;
         allz <= 1'b0; par_acc <= 1'b0; par_bad <= 1'b0;
         done <= 1'b0; frame <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            S_IDLE: if (tick && !rx) begin
               st  <= S_START;
               cnt <= '0;
            end
            S_START: if (tick) begin
               if (cnt == MID) begin
                  cnt <= '0;
                  if (rx) st <= S_IDLE;
                  else begin
                     st <= S_DATA; idx <= '0; sh <= '0;
                     allz <= 1'b1; par_acc <= 1'b0; par_bad <= 1'b0;
                  end
               end else cnt <= cnt + 1'b1;
            end
            S_DATA: if (tick) begin
               if (cnt == LAST) begin
                  cnt     <= '0;
                  sh      <= {rx, sh[SRX_MAXB-1:1]};
                  allz    <= allz & ~rx;
                  par_acc <= par_acc ^ rx;
                  if (idx == nbits - 4'd1) st <= par_en ? S_PAR : S_STOP;
                  else                     idx <= idx + 4'd1;
               end else cnt <= cnt + 1'b1;
            end
            S_PAR: if (tick) begin
               if (cnt == LAST) begin
                  cnt     <= '0;
                  par_bad <= (par_acc ^ rx) != par_odd;
                  allz    <= allz & ~rx;
                  st      <= S_STOP;
               end else cnt <= cnt + 1'b1;
            end
            S_STOP: if (tick) begin
               if (cnt == LAST) begin
                  cnt           <= '0;
                  done          <= 1'b1;
                  frame.data    <= sh >> (4'd9 - nbits);
                  frame.stop_ok <= rx;
                  frame.par_bad <= par_bad;
                  frame.all_low <= allz & ~rx;
                  st            <= rx ? S_IDLE : S_HOLD;
               end else cnt <= cnt + 1'b1;
            end
            S_HOLD: if (rx) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign active = (st == S_HOLD);

   // R10: a start bit that is high again at its middle sample is dropped
   a_r10_start_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_START && tick && cnt == MID && rx) |=> (st == S_IDLE));

   // R7: a low stop sample leaves the receiver waiting for a high line
   a_r7_hold_after_low_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !frame.stop_ok) |-> active);
endmodule

// File: rtl/srx_status.sv
module srx_status
   import srx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  srx_frame_t          frame,
   input  logic                nine,
   input  logic                rd_data,
   input  logic                rd_status,
   input  logic                attn_we,
   input  logic                attn_d,
   input  logic                ie_we,
   input  logic                ie_d,
   output logic [SRX_MAXB-1:0] data_q,
   output logic                bit9_q,
   output logic                full_q,
   output logic                ovr_q,
   output logic                fe_q,
   output logic                pe_q,
   output logic                brk_q,
   output logic                attn_q,
   output logic                ie_q,
   output logic                err,
   output logic                irq
);
   logic is_addr, accept, load, is_brk;

   assign is_addr = nine & frame.data[SRX_MAXB-1];
   assign accept  = done & (~attn_q | is_addr);
   assign load    = accept & (~full_q | rd_data);
   assign is_brk  = frame.all_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0; bit9_q <= 1'b0; full_q <= 1'b0;
         ovr_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0; brk_q <= 1'b0;
         attn_q <= 1'b0; ie_q <= 1'b0;
      end else begin
         if (load) begin
            data_q <= frame.data;
            bit9_q <= is_addr;
            full_q <= 1'b1;
         end else if (rd_data) full_q <= 1'b0;

         ovr_q <= (ovr_q & ~rd_status) | (accept & full_q & ~rd_data);
         fe_q  <= (fe_q  & ~rd_status) | (accept & ~frame.stop_ok & ~is_brk);
         pe_q  <= (pe_q  & ~rd_status) | (accept & frame.par_bad & ~is_brk);
         brk_q <= (brk_q & ~rd_status) | (accept & is_brk);

         if (attn_we)                    attn_q <= attn_d;
         else if (accept && is_addr)     attn_q <= 1'b0;

         if (ie_we) ie_q <= ie_d;
      end
   end

   assign err = ovr_q | fe_q | pe_q | brk_q;
   assign irq = ie_q & (full_q | err);

   // R4: overrun leaves the held character untouched
   a_r4_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && accept && full_q && !rd_data) |=> ($stable(data_q) && ovr_q));

   // R3: a buffer read with nothing arriving empties the buffer
   a_r3_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !done) |=> !full_q);

   // R8: a status read with nothing arriving clears every sticky flag
   a_r8_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !done) |=> !(ovr_q || fe_q || pe_q || brk_q));

   // R9: an address character ends attention mode
   a_r9_attn_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (attn_q && done && is_addr && !attn_we) |=> !attn_q);

   // R9: a dropped character never fills the buffer
   a_r9_drop_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (attn_q && done && !is_addr && !full_q && !rd_data) |=> !full_q);

   // R12: no request while disabled
   a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_q |-> !irq);
endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
   import srx_pkg::*;
#(
   parameter int unsigned OSR         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_CLK_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick_i,
   input  logic       ext_clk_i,
   input  logic       clk_sel_i,
   input  logic       rx_i,
   input  logic       tx_loop_i,
   input  logic [1:0] frame_mode_i,
   input  logic       parity_en_i,
   input  logic       parity_odd_i,
   input  logic       attn_we_i,
   input  logic       attn_d_i,
   input  logic       ie_we_i,
   input  logic       ie_d_i,
   input  logic       rd_data_i,
   input  logic       rd_status_i,
   output logic [8:0] rx_data_o,
   output logic       bit9_o,
   output logic       full_o,
   output logic       overrun_o,
   output logic       framing_o,
   output logic       parity_o,
   output logic       break_o,
   output logic       err_o,
   output logic       rx_active_o,
   output logic       attn_o,
   output logic       irq_o
);
   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("serial_rx_top: OSR must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_rx_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       loop_sel, nine, par_en_eff, rx_s, tick, done, ie_q;
   logic [3:0] nbits;
   srx_frame_t frame;

   always_comb begin
      unique case (frame_mode_i)
         2'b01:   nbits = 4'd7;
         2'b10,
         2'b11:   nbits = 4'd9;
         default: nbits = 4'd8;
      endcase
   end

   assign loop_sel   = (frame_mode_i == 2'b11);
   assign nine       = (nbits == 4'd9);
   assign par_en_eff = parity_en_i & ~nine;

   srx_insel #(.SYNC_STAGES(SYNC_STAGES), .EXT_CLK_EN(EXT_CLK_EN)) u_insel (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .loop_i(tx_loop_i),
      .loop_sel(loop_sel), .ext_clk_i(ext_clk_i), .clk_sel(clk_sel_i),
      .baud_tick_i(baud_tick_i), .rx_s(rx_s), .tick(tick));

   srx_deframe #(.OSR(OSR)) u_deframe (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .nbits(nbits),
      .par_en(par_en_eff), .par_odd(parity_odd_i), .done(done),
      .frame(frame), .active(rx_active_o));

   srx_status u_status (
      .clk(clk), .rst_n(rst_n), .done(done), .frame(frame), .nine(nine),
      .rd_data(rd_data_i), .rd_status(rd_status_i),
      .attn_we(attn_we_i), .attn_d(attn_d_i), .ie_we(ie_we_i), .ie_d(ie_d_i),
      .data_q(rx_data_o), .bit9_q(bit9_o), .full_q(full_o),
      .ovr_q(overrun_o), .fe_q(framing_o), .pe_q(parity_o), .brk_q(break_o),
      .attn_q(attn_o), .ie_q(ie_q), .err(err_o), .irq(irq_o));

   // R2: nine-bit modes mirror the top data bit into bit9_o
   a_r2_bit9_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      bit9_o |-> rx_data_o[8]);
endmodule

// File: tb/tb_serial_rx_top.sv
module tb_serial_rx_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic baud_tick_i = 1'b0, ext_clk_i = 1'b0, clk_sel_i = 1'b0;
   logic rx_i = 1'b1, tx_loop_i = 1'b1;
   logic [1:0] frame_mode_i = 2'b00;
   logic parity_en_i = 1'b0, parity_odd_i = 1'b0;
   logic attn_we_i = 1'b0, attn_d_i = 1'b0, ie_we_i = 1'b0, ie_d_i = 1'b0;
   logic rd_data_i = 1'b0, rd_status_i = 1'b0;
   logic [8:0] rx_data_o;
   logic bit9_o, full_o, overrun_o, framing_o, parity_o, break_o, err_o;
   logic rx_active_o, attn_o, irq_o;

   serial_rx_top dut (.*);

   int tick_cnt = 0, ext_cnt = 0;
   always @(posedge clk) begin
      tick_cnt    <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
      baud_tick_i <= (tick_cnt == 3);
      ext_cnt     <= (ext_cnt == 3) ? 0 : ext_cnt + 1;
      if (ext_cnt == 3) ext_clk_i <= ~ext_clk_i;
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [8:0] m_data = '0;
   bit m_bit9 = 0, m_full = 0, m_ovr = 0, m_fe = 0, m_pe = 0, m_brk = 0;
   bit m_attn = 0, m_ie = 0, use_loop = 0;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      bit e;
      e = m_ovr | m_fe | m_pe | m_brk;
      chk(req, "rx_data", int'(rx_data_o), int'(m_data));
      chk(req, "bit9", int'(bit9_o), int'(m_bit9));
      chk(req, "full", int'(full_o), int'(m_full));
      chk(req, "overrun", int'(overrun_o), int'(m_ovr));
      chk(req, "framing", int'(framing_o), int'(m_fe));
      chk(req, "parity", int'(parity_o), int'(m_pe));
      chk(req, "break", int'(break_o), int'(m_brk));
      chk(req, "err", int'(err_o), int'(e));
      chk(req, "attn", int'(attn_o), int'(m_attn));
      chk(req, "irq", int'(irq_o), int'(m_ie & (m_full | e)));
   endtask

   task automatic line(bit v);
      if (use_loop) tx_loop_i = v; else rx_i = v;
   endtask

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask

   // Sends one frame and updates the reference model; the line is left at stopv.
   task automatic send(int nb, logic [8:0] d, bit use_par, bit pbit, bit stopv, int bitclk);
      logic [8:0] md;
      bit nine, addr, brk, pbad;
      md = d & 9'((1 << nb) - 1);
      line(1'b0); hold(bitclk);
      for (int i = 0; i < nb; i++) begin line(md[i]); hold(bitclk); end
      if (use_par) begin line(pbit); hold(bitclk); end
      line(stopv); hold(bitclk);
      hold(bitclk);
      nine = (nb == 9);
      addr = nine & md[8];
      brk  = (md == 0) && (!use_par || !pbit) && !stopv;
      pbad = use_par && ((^md ^ pbit) != parity_odd_i);
      if (!m_attn || addr) begin
         if (m_full) m_ovr = 1;
         else begin m_data = md; m_bit9 = addr; m_full = 1; end
         if (!stopv && !brk) m_fe = 1;
         if (pbad && !brk) m_pe = 1;
         if (brk) m_brk = 1;
         if (m_attn && addr) m_attn = 0;
      end
   endtask

   task automatic read_data();
      rd_data_i = 1; hold(1); rd_data_i = 0; hold(1);
      m_full = 0;
   endtask

   task automatic read_status();
      rd_status_i = 1; hold(1); rd_status_i = 0; hold(1);
      m_ovr = 0; m_fe = 0; m_pe = 0; m_brk = 0;
   endtask

   initial begin
      hold(150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      hold(3); rst_n = 1; hold(3);
      // R1 reset state
      check_all("R1");
      chk("R1", "rx_active", int'(rx_active_o), 0);

      // R2 eight-bit character, enable still 0 (R12)
      send(8, 9'h0A5, 0, 0, 1, 64);
      check_all("R2");
      chk("R12", "irq_disabled", int'(irq_o), 0);
      read_data(); check_all("R3");

      // R12/R3 enable the request
      ie_we_i = 1; ie_d_i = 1; hold(1); ie_we_i = 0; m_ie = 1; hold(1);
      send(8, 9'h03C, 0, 0, 1, 64);
      check_all("R3");
      read_data(); check_all("R3");

      // R2 seven-bit mode drops bit 7
      frame_mode_i = 2'b01;
      send(7, 9'h0D5, 0, 0, 1, 64);
      check_all("R2");
      read_data();

      // R2 nine-bit mode
      frame_mode_i = 2'b10;
      send(9, 9'h1A3, 0, 0, 1, 64);
      check_all("R2");
      read_data();

      // R4 overrun, then R8 status clear
      frame_mode_i = 2'b00;
      send(8, 9'h011, 0, 0, 1, 64);
      send(8, 9'h022, 0, 0, 1, 64);
      check_all("R4");
      read_status(); check_all("R8");
      read_data();

      // R5 parity even good/bad, odd good
      parity_en_i = 1; parity_odd_i = 0;
      send(8, 9'h007, 1, 1, 1, 64); check_all("R5"); read_data();
      send(8, 9'h007, 1, 0, 1, 64); check_all("R5"); read_data();
      read_status();
      parity_odd_i = 1;
      send(8, 9'h007, 1, 0, 1, 64); check_all("R5"); read_data();
      // R5 no parity bit in nine-bit mode
      frame_mode_i = 2'b10;
      send(9, 9'h0FF, 0, 0, 1, 64); check_all("R5"); read_data();
      parity_en_i = 0; parity_odd_i = 0; frame_mode_i = 2'b00;

      // R6 framing error, R7 rx_active
      send(8, 9'h081, 0, 0, 0, 64);
      check_all("R6");
      chk("R7", "rx_active_low_line", int'(rx_active_o), 1);
      line(1'b1); hold(8);
      chk("R7", "rx_active_released", int'(rx_active_o), 0);
      read_data(); read_status(); check_all("R8");

      // R7 break
      send(8, 9'h000, 0, 0, 0, 64);
      check_all("R7");
      chk("R7", "rx_active_break", int'(rx_active_o), 1);
      line(1'b1); hold(128);
      chk("R7", "rx_active_after_break", int'(rx_active_o), 0);
      check_all("R7");
      read_data(); read_status();

      // R10 quarter-bit glitch
      line(1'b0); hold(16); line(1'b1); hold(256);
      check_all("R10");

      // R9 attention mode
      frame_mode_i = 2'b10;
      attn_we_i = 1; attn_d_i = 1; hold(1); attn_we_i = 0; m_attn = 1; hold(1);
      check_all("R9");
      send(9, 9'h055, 0, 0, 1, 64); check_all("R9");
      send(9, 9'h1F0, 0, 0, 1, 64); check_all("R9");
      read_data();

      // R11 external tick source (bit = 128 clocks)
      frame_mode_i = 2'b00; clk_sel_i = 1; hold(4);
      send(8, 9'h096, 0, 0, 1, 128); check_all("R11");
      read_data(); clk_sel_i = 0; hold(4);

      // R2 loopback: rx_i held low and ignored
      frame_mode_i = 2'b11; hold(2);
      rx_i = 0; use_loop = 1; hold(64);
      send(9, 9'h12C, 0, 0, 1, 64);
      check_all("R2");
      chk("R2", "loop_rx_active", int'(rx_active_o), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule